// File: doc/BRIEF.md
# Branchless Relative-Offset Accumulator Core

This block is a small processor core with one W-bit accumulator, a program counter and a single synchronous memory port that serves both instruction fetches and data accesses. It has four instructions: unconditional jump, load, store and increment-in-memory. It has no conditional branch. Every operand is a signed offset from the address of the instruction that carries it, so a program can be placed anywhere in memory without change.

Decisions are made by running data as code. A cell holding 0 decodes as a jump to itself, and a cell holding 1 decodes as a jump to the next cell. A program stores a computed bit into a cell it is about to fetch, or patches its own offset fields with the in-memory increment. A copy loop ends when the loop overwrites its own first instruction. A cell of all zeros is a self-loop, which programs use as a resting point.

The memory sits outside the core and has a one-cycle read latency, like an inferred block RAM. All port outputs are registered.

Top module: `rbc_core`

## Requirements
- R1: While reset is high, the core holds pc_o at 0, acc_o at 0, mem_addr at 0 and mem_we low. After reset is released, the first fetch comes from address 0.
- R2: An instruction word uses bits [W-1:W-2] as the opcode: 00 jump, 01 load, 10 store, 11 increment. Bits [W-3:0] are a two's complement offset. The effective address is the instruction's own address plus the sign-extended offset, modulo 2^AW.
- R3: A jump sets the program counter to the effective address. The next fetch is from that address, and the jump writes nothing.
- R4: A load copies the memory word at the effective address into the accumulator. The program counter then advances by one.
- R5: A store writes the accumulator to the effective address and leaves the accumulator unchanged. The program counter then advances by one.
- R6: An increment adds one to the whole W-bit word at the effective address, wrapping modulo 2^W. A carry out of the offset field spills into the opcode bits. The accumulator is unchanged, and the program counter advances by one.
- R7: A word equal to 0 executes as a jump to its own address. A word equal to 1 executes as a jump to the following address.
- R8: A store or increment that targets the next instruction to be fetched is seen by that fetch. An old copy of the cell is never executed. This also holds when a loop overwrites its own first instruction.
- R9: mem_we is high for exactly one cycle per store or increment and is never high in two consecutive cycles. Read data is used in the cycle after its address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | AW | Registered memory address for fetch, read and write |
| mem_we | output | 1 | Registered write enable |
| mem_wdata | output | W | Registered write data |
| mem_rdata | input | W | Word read from the previous cycle's mem_addr |
| pc_o | output | AW | Current program counter |
| acc_o | output | W | Current accumulator |

## Verification
The bench targets several corner cases:
- Negative offsets that wrap below address 0. A core that zero-extends the offset would load from or jump to the wrong cell.
- An increment of 0xFFF. It must wrap to 0 with no carry kept. An increment of an offset field must carry into the opcode bits, so a core that increments only the offset field would leave the opcode wrong.
- Data words 0 and 1 executed as jumps. A stored bit is placed in the very next cell, whose previous content was a jump elsewhere; a core that fetched an old copy would end at the wrong address.
- A copy loop that stops by overwriting its own first instruction. Any reordering of the write against the following fetch leaves the loop running forever or ends it at the wrong place.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  typedef enum logic [1:0] {
    OP_GOTO  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_INC   = 2'b11
  } opcode_e;

  typedef enum logic [2:0] {
    S_FETCH,
    S_DECODE,
    S_MEMRD,
    S_LOADW,
    S_INCW,
    S_WRITE
  } seq_state_e;

endpackage

// File: rtl/rbc_ea_unit.sv
// Splits a fetched word into opcode and offset, and forms base + signed offset.
module rbc_ea_unit
  import rbc_pkg::*;
#(
  parameter int W  = 12,
  parameter int AW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [W-1:0]  word,
  output opcode_e       op,
  output logic [AW-1:0] ea
);
  localparam int OFFW = W - 2;

  logic [AW-1:0] off_ext;

  generate
    if (OFFW >= AW) begin : g_trunc
      // wrap modulo memory size: upper offset bits cannot change the sum
      assign off_ext = word[AW-1:0];
    end else begin : g_sext
      assign off_ext = {{(AW-OFFW){word[OFFW-1]}}, word[OFFW-1:0]};
    end
  endgenerate

  assign op = opcode_e'(word[W-1:W-2]);
  assign ea = base + off_ext;

endmodule

// File: rtl/rbc_sequencer.sv
// Multi-cycle control: fetch, decode, optional read, optional write.
module rbc_sequencer
  import rbc_pkg::*;
#(
  parameter int W  = 12,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  mem_rdata,
  input  opcode_e       dec_op,
  input  logic [AW-1:0] dec_ea,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [W-1:0]  mem_wdata,
  output logic [AW-1:0] pc,
  output logic [W-1:0]  acc,
  output seq_state_e    state,
  output opcode_e       op_q
);
  logic [AW-1:0] pc_next;
  assign pc_next = pc + AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_FETCH;
      pc        <= '0;
      acc       <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      op_q      <= OP_GOTO;
    end else begin
      case (state)
        S_FETCH: state <= S_DECODE;
        S_DECODE: begin
          op_q <= dec_op;
          mem_addr <= dec_ea;
          case (dec_op)
            OP_GOTO: begin
              pc    <= dec_ea;
              state <= S_FETCH;
            end
            OP_STORE: begin
              mem_we    <= 1'b1;
              mem_wdata <= acc;
              state     <= S_WRITE;
            end
            default: state <= S_MEMRD;
          endcase
        end
        S_MEMRD: state <= (op_q == OP_LOAD) ? S_LOADW : S_INCW;
        S_LOADW: begin
          acc      <= mem_rdata;
          pc       <= pc_next;
          mem_addr <= pc_next;
          state    <= S_FETCH;
        end
        S_INCW: begin
          mem_we    <= 1'b1;
          mem_wdata <= mem_rdata + W'(1);
          state     <= S_WRITE;
        end
        S_WRITE: begin
          // write completes at this edge, strictly before the next fetch
          mem_we   <= 1'b0;
          pc       <= pc_next;
          mem_addr <= pc_next;
          state    <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

endmodule

// File: rtl/rbc_core.sv
module rbc_core
  import rbc_pkg::*;
#(
  parameter int W  = 12,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic [AW-1:0] pc_o,
  output logic [W-1:0]  acc_o
);
  opcode_e       dec_op;
  logic [AW-1:0] dec_ea;
  seq_state_e    seq_state;
  opcode_e       seq_op;

  rbc_ea_unit #(.W(W), .AW(AW)) u_ea (
    .base (pc_o),
    .word (mem_rdata),
    .op   (dec_op),
    .ea   (dec_ea)
  );

  rbc_sequencer #(.W(W), .AW(AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (mem_rdata),
    .dec_op    (dec_op),
    .dec_ea    (dec_ea),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .pc        (pc_o),
    .acc       (acc_o),
    .state     (seq_state),
    .op_q      (seq_op)
  );

endmodule

// File: rtl/rbc_core_chk.sv
module rbc_core_chk
  import rbc_pkg::*;
#(
  parameter int W  = 12,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic [W-1:0]  mem_wdata,
  input logic [W-1:0]  mem_rdata,
  input logic [AW-1:0] pc,
  input logic [W-1:0]  acc,
  input seq_state_e    state,
  input opcode_e       op
);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (pc == '0 && acc == '0 && !mem_we && mem_addr == '0));

  assert_fetch_at_pc_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |-> (mem_addr == pc && !mem_we));

  assert_store_data_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && op == OP_STORE) |-> (mem_wdata == acc));

  assert_acc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $stable(acc));

  assert_inc_data_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && op == OP_INC) |-> (mem_wdata == $past(mem_rdata) + W'(1)));

  assert_one_write_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

endmodule

bind rbc_core rbc_core_chk #(.W(W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .pc        (pc_o),
  .acc       (acc_o),
  .state     (seq_state),
  .op        (seq_op)
);

// File: tb/tb_rbc_core.sv
module tb_rbc_core;
  localparam int W     = 12;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [W-1:0]  mem_wdata;
  logic [W-1:0]  mem_rdata;
  logic [AW-1:0] pc_o;
  logic [W-1:0]  acc_o;

  logic          clr = 1'b0;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [W-1:0]  ld_data = '0;
  logic [W-1:0]  mem [DEPTH];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 8 ns period

  rbc_core #(.W(W), .AW(AW)) dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_o(pc_o), .acc_o(acc_o)
  );

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung actual=%0d expected<100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wipe();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk); ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic go(input int n);
    @(negedge clk); rst = 1'b0;
    repeat (n) @(negedge clk);
    rst = 1'b1;
  endtask

  typedef struct packed {
    logic [W-1:0]  instr;
    logic [AW-1:0] daddr;
    logic [W-1:0]  dval;
    logic [AW-1:0] exp_pc;
    logic [W-1:0]  exp_acc;
    logic [W-1:0]  exp_mem;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{12'h405, 8'd5,   12'h123, 8'd1,   12'h123, 12'h123}, // R4 load +5
    '{12'h7FF, 8'd255, 12'hABC, 8'd1,   12'hABC, 12'hABC}, // R2 load -1 wraps
    '{12'hC03, 8'd3,   12'h7FF, 8'd1,   12'h000, 12'h800}, // R6 carry into opcode
    '{12'hC03, 8'd3,   12'hFFF, 8'd1,   12'h000, 12'h000}, // R6 wrap to zero
    '{12'h804, 8'd4,   12'h555, 8'd1,   12'h000, 12'h000}, // R5 store acc
    '{12'h007, 8'd7,   12'h000, 8'd7,   12'h000, 12'h000}, // R3 jump +7
    '{12'h3FE, 8'd254, 12'h000, 8'd254, 12'h000, 12'h000}, // R3 jump -2 wraps
    '{12'hC00, 8'd0,   12'hC00, 8'd1,   12'h000, 12'hC01}, // R6 self increment
    '{12'h001, 8'd2,   12'h000, 8'd1,   12'h000, 12'h000}, // R7 word 1
    '{12'h000, 8'd2,   12'h000, 8'd0,   12'h000, 12'h000}  // R7 word 0
  };

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 pc", 32'(pc_o), 32'd0);
    chk("R1 acc", 32'(acc_o), 32'd0);
    chk("R1 we", 32'(mem_we), 32'd0);
    chk("R1 addr", 32'(mem_addr), 32'd0);

    for (int v = 0; v < NV; v++) begin
      wipe();
      put(8'd0, VECS[v].instr);
      put(VECS[v].daddr, VECS[v].dval);
      go(60);
      chk($sformatf("R2 vec%0d pc", v), 32'(pc_o), 32'(VECS[v].exp_pc));
      chk($sformatf("R4 vec%0d acc", v), 32'(acc_o), 32'(VECS[v].exp_acc));
      chk($sformatf("R6 vec%0d mem", v), 32'(mem[VECS[v].daddr]), 32'(VECS[v].exp_mem));
    end

    // R5: load then store into a neighbour
    wipe();
    put(8'd0, 12'h40A);   // load +10
    put(8'd1, 12'h80A);   // store +10 -> cell 11
    put(8'd10, 12'h5A5);
    go(60);
    chk("R5 stored word", 32'(mem[11]), 32'h5A5);
    chk("R5 acc kept", 32'(acc_o), 32'h5A5);
    chk("R5 pc", 32'(pc_o), 32'd2);

    // R8/R7: computed bit stored into the next cell, then executed
    for (int b = 0; b < 2; b++) begin
      wipe();
      put(8'd0, 12'h414);   // load +20
      put(8'd1, 12'h801);   // store +1 -> cell 2
      put(8'd2, 12'h005);   // old content: jump +5 (must not run)
      put(8'd20, 12'(b));
      go(60);
      chk($sformatf("R8 bit%0d pc", b), 32'(pc_o), 32'(2 + b));
      chk($sformatf("R7 bit%0d cell", b), 32'(mem[2]), 32'(b));
    end

    // R8: copy loop ends by overwriting its own first instruction
    wipe();
    put(8'd0,  12'h00A);  // jump +10
    put(8'd10, 12'h414);  // load +20 (src 30)
    put(8'd11, 12'hBFB);  // store -5 (dst 6)
    put(8'd12, 12'hFFE);  // inc -2 -> 10
    put(8'd13, 12'hFFE);  // inc -2 -> 11
    put(8'd14, 12'h3FC);  // jump -4 -> 10
    put(8'd30, 12'h111);
    put(8'd31, 12'h222);
    put(8'd32, 12'h333);
    put(8'd33, 12'h444);
    put(8'd34, 12'h009);  // lands on 10, bumped to jump +10
    go(400);
    chk("R8 copy w0", 32'(mem[6]), 32'h111);
    chk("R8 copy w3", 32'(mem[9]), 32'h444);
    chk("R8 patched head", 32'(mem[10]), 32'h00A);
    chk("R6 store field carry", 32'(mem[11]), 32'hC00);
    chk("R8 exit pc", 32'(pc_o), 32'd20);
    chk("R4 last load", 32'(acc_o), 32'h009);

    // R1: reset again after a run
    @(negedge clk);
    @(negedge clk);
    chk("R1 re-reset pc", 32'(pc_o), 32'd0);
    chk("R1 re-reset acc", 32'(acc_o), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule